// File: doc/BRIEF.md
# System-management memory window control registers

This block holds the two byte-wide control registers that govern the system-management memory window of a host bridge. A primary register carries the window-open bit, a close bit, a one-way lock bit, a global enable and a three-bit base-segment field. A secondary register carries a high-window enable, a two-bit top-segment size and a top-segment enable. Both registers are reached over a simple byte-wide configuration port (write strobe, address, write data, combinational read data). The stored fields are also brought out as decoded enables for the downstream address decoder.

Once firmware sets the lock bit, the open bit is held at zero. The fields that define where and whether the protected window exists become read-only until the platform reset input is asserted. That input is asserted at power-up and on a software-requested platform reset. A separate sleep-resume pulse either leaves the lock alone or drops only the lock bit, depending on a build parameter. In the second case, resume firmware can reopen the window, restore it and lock it again before the operating system runs.

Top module: `smm_window_regs`

## Requirements
- R1: After the platform reset input (rst_n, active low) is released, the primary register reads 0x02, the secondary register reads 0x00, and the block is unlocked.
- R2: While unlocked, a write to the primary address (0x10) or the secondary address (0x11) stores all eight data bits as written. The only exceptions are those given in R4 and R7.
- R3: Writing 1 to primary bit 4 (lock) sets the lock from the next clock on. Writes never clear it. Only rst_n clears it, plus the resume pulse when R8 allows.
- R4: Whenever primary bit 4 is set, primary bit 6 (open) is stored and read as 0. This includes a single write that sets both bits.
- R5: While locked, writes leave primary bits 6, 4, 3 and 2:0 unchanged, while bits 7 and 5 stay writable. The lock state used is the one before the write.
- R6: While locked, writes leave secondary bits 7, 2:1 and 0 unchanged, while bits 6:3 stay writable.
- R7: A write with primary bits 6 and 5 both set (open and close) leaves bit 6 at 0.
- R8: A resume pulse clears only the lock bit when RESUME_CLEARS_LOCK is 1, after which writes behave as unlocked. When the parameter is 0, the pulse changes nothing.
- R9: The outputs show the stored fields at all times:
  - win_open = primary bit 6
  - lock_active = primary bit 4
  - glob_en = primary bit 3
  - base_seg = primary bits 2:0
  - high_en = secondary bit 7
  - tseg_size = secondary bits 2:1
  - tseg_en = secondary bit 0
- R10: Any address other than the two register addresses reads 0x00, and a write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform (full) reset, active low, asynchronous assert |
| resume_evt | input | 1 | One-cycle sleep-resume pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| win_open | output | 1 | Window forced visible |
| lock_active | output | 1 | Lock bit state |
| glob_en | output | 1 | Global window enable |
| base_seg | output | 3 | Base segment select |
| high_en | output | 1 | High window enable |
| tseg_size | output | 2 | Top segment size code |
| tseg_en | output | 1 | Top segment enable |

## Verification
The assertions assume that the resume pulse is not issued in the same cycle as a write that the checked property depends on. They also assume that rst_n is only released away from a clock edge. The stimulus applies every write and every resume pulse in separate clock cycles. It changes inputs on the falling edge only, and it releases reset between edges. Two instances, one for each resume variant, share all inputs, so the same write sequence exercises both lock policies.

// File: rtl/smm_window_pkg.sv
package smm_window_pkg;
  localparam int unsigned DATA_W = 8;

  // primary register bit positions
  localparam int unsigned P_OPEN  = 6;
  localparam int unsigned P_CLOSE = 5;
  localparam int unsigned P_LOCK  = 4;
  localparam int unsigned P_GLOB  = 3;
  localparam int unsigned P_BASE_LO = 0;
  localparam int unsigned BASE_W  = 3;

  // secondary register bit positions
  localparam int unsigned S_HIGH  = 7;
  localparam int unsigned S_SIZE_LO = 1;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned S_TSEG  = 0;

  // fields frozen by the lock
  localparam logic [DATA_W-1:0] PRI_FROZEN = 8'h5F;
  localparam logic [DATA_W-1:0] SEC_FROZEN = 8'h87;
  localparam logic [DATA_W-1:0] ALL_ONES   = {DATA_W{1'b1}};
endpackage

// File: rtl/smm_cfg_byte.sv
module smm_cfg_byte
  import smm_window_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    merged = wr_en ? ((q & ~wmask) | (wdata & wmask)) : q;
    q_nxt  = merged & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/smm_lock_ctrl.sv
module smm_lock_ctrl
  import smm_window_pkg::*;
#(
  parameter bit RESUME_CLEARS_LOCK = 1'b1
) (
  input  logic              locked,
  input  logic              wr_pri,
  input  logic              wr_open,
  input  logic              wr_close,
  input  logic              wr_lock,
  input  logic              resume_evt,
  output logic [DATA_W-1:0] pri_mask,
  output logic [DATA_W-1:0] sec_mask,
  output logic [DATA_W-1:0] pri_clr,
  output logic [DATA_W-1:0] sec_clr
);
  logic lock_nxt;
  logic resume_drop;

  generate
    if (RESUME_CLEARS_LOCK) begin : g_resume_drop
      assign resume_drop = resume_evt;
    end else begin : g_resume_keep
      assign resume_drop = 1'b0;
    end
  endgenerate

  always_comb begin
    pri_mask = locked ? ~PRI_FROZEN : ALL_ONES;
    sec_mask = locked ? ~SEC_FROZEN : ALL_ONES;
    lock_nxt = locked | (wr_pri & wr_lock);
    pri_clr  = '0;
    sec_clr  = '0;
    if (lock_nxt || (!locked && wr_pri && wr_open && wr_close))
      pri_clr[P_OPEN] = 1'b1;
    if (resume_drop)
      pri_clr[P_LOCK] = 1'b1;
  end
endmodule

// File: rtl/smm_window_regs.sv
module smm_window_regs
  import smm_window_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 8'h11,
  parameter logic [7:0]        PRI_RST  = 8'h02,
  parameter logic [7:0]        SEC_RST  = 8'h00,
  parameter bit                RESUME_CLEARS_LOCK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resume_evt,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              win_open,
  output logic              lock_active,
  output logic              glob_en,
  output logic [2:0]        base_seg,
  output logic              high_en,
  output logic [1:0]        tseg_size,
  output logic              tseg_en
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  logic [DATA_W-1:0]      pri_q, sec_q;
  logic [DATA_W-1:0]      pri_mask, sec_mask, pri_clr, sec_clr;
  logic                   hit_pri, hit_sec, wr_pri, wr_sec;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  always_comb begin
    hit_pri = (cfg_addr == PRI_ADDR);
    hit_sec = (cfg_addr == SEC_ADDR);
    wr_pri  = cfg_wr & hit_pri;
    wr_sec  = cfg_wr & hit_sec;
  end

  smm_lock_ctrl #(.RESUME_CLEARS_LOCK(RESUME_CLEARS_LOCK)) u_lock (
    .locked     (pri_q[P_LOCK]),
    .wr_pri     (wr_pri),
    .wr_open    (cfg_wdata[P_OPEN]),
    .wr_close   (cfg_wdata[P_CLOSE]),
    .wr_lock    (cfg_wdata[P_LOCK]),
    .resume_evt (resume_evt),
    .pri_mask   (pri_mask),
    .sec_mask   (sec_mask),
    .pri_clr    (pri_clr),
    .sec_clr    (sec_clr)
  );

  smm_cfg_byte #(.RST_VAL(PRI_RST)) u_pri (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_pri), .wdata(cfg_wdata),
    .wmask(pri_mask), .clr(pri_clr), .q(pri_q)
  );

  smm_cfg_byte #(.RST_VAL(SEC_RST)) u_sec (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_sec), .wdata(cfg_wdata),
    .wmask(sec_mask), .clr(sec_clr), .q(sec_q)
  );

  always_comb begin
    cfg_rdata = '0;
    if (hit_pri)      cfg_rdata = pri_q;
    else if (hit_sec) cfg_rdata = sec_q;
  end

  assign win_open    = pri_q[P_OPEN];
  assign lock_active = pri_q[P_LOCK];
  assign glob_en     = pri_q[P_GLOB];
  assign base_seg    = pri_q[P_BASE_LO +: BASE_W];
  assign high_en     = sec_q[S_HIGH];
  assign tseg_size   = sec_q[S_SIZE_LO +: SIZE_W];
  assign tseg_en     = sec_q[S_TSEG];

  // ---------------- assertions ----------------
  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_pri && cfg_wdata[P_LOCK] && !resume_evt) |=> pri_q[P_LOCK]);

  p_open_low_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    pri_q[P_LOCK] |-> !pri_q[P_OPEN]);

  p_pri_frozen_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pri_q[P_LOCK] && !resume_evt) |=> $stable(pri_q & PRI_FROZEN));

  p_sec_frozen_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pri_q[P_LOCK] && !resume_evt) |=> $stable(sec_q & SEC_FROZEN));

  p_close_wins_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_pri && cfg_wdata[P_OPEN] && cfg_wdata[P_CLOSE]) |=> !pri_q[P_OPEN]);

  generate
    if (RESUME_CLEARS_LOCK) begin : g_chk_drop
      p_resume_drop_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        resume_evt |=> !pri_q[P_LOCK]);
    end else begin : g_chk_keep
      p_resume_keep_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        pri_q[P_LOCK] |=> pri_q[P_LOCK]);
    end
  endgenerate
endmodule

// File: tb/smm_window_regs_bench.sv
module smm_window_regs_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [7:0] PA = 8'h10;
  localparam logic [7:0] SA = 8'h11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       resume_evt = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic       wo_a, lk_a, ge_a, he_a, te_a;
  logic [2:0] bs_a;
  logic [1:0] ts_a;
  logic       wo_b, lk_b, ge_b, he_b, te_b;
  logic [2:0] bs_b;
  logic [1:0] ts_b;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  smm_window_regs #(.RESUME_CLEARS_LOCK(1'b1)) u_smm_window_regs (
    .clk(clk), .rst_n(rst_n), .resume_evt(resume_evt), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a),
    .win_open(wo_a), .lock_active(lk_a), .glob_en(ge_a), .base_seg(bs_a),
    .high_en(he_a), .tseg_size(ts_a), .tseg_en(te_a));

  smm_window_regs #(.RESUME_CLEARS_LOCK(1'b0)) u_smm_window_regs_hold (
    .clk(clk), .rst_n(rst_n), .resume_evt(resume_evt), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b),
    .win_open(wo_b), .lock_active(lk_b), .glob_en(ge_b), .base_seg(bs_b),
    .high_en(he_b), .tseg_size(ts_b), .tseg_en(te_b));

  // reference models (one per resume variant)
  logic [7:0] pa_m, sa_m, pb_m, sb_m;

  typedef struct {
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  chk_ev;

  function automatic logic [7:0] nxt_pri(input logic [7:0] old, input logic [7:0] w);
    logic [7:0] m, n;
    m = old[4] ? 8'hA0 : 8'hFF;
    n = (old & ~m) | (w & m);
    if (!old[4] && w[6] && w[5]) n[6] = 1'b0;
    if (n[4]) n[6] = 1'b0;
    return n;
  endfunction

  function automatic logic [7:0] nxt_sec(input logic lk, input logic [7:0] old, input logic [7:0] w);
    logic [7:0] m;
    m = lk ? 8'h78 : 8'hFF;
    return (old & ~m) | (w & m);
  endfunction

  // monitor: pops expected read items and compares
  always @(chk_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (rd_a !== it.exp_a || rd_b !== it.exp_b) begin
        n_fail++;
        $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h",
                 it.tag, rd_a, rd_b, it.exp_a, it.exp_b);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pa_m = 8'h02; sa_m = 8'h00; pb_m = 8'h02; sb_m = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == PA) begin
      sa_m = sa_m; sb_m = sb_m;
      pa_m = nxt_pri(pa_m, d); pb_m = nxt_pri(pb_m, d);
    end else if (a == SA) begin
      sa_m = nxt_sec(pa_m[4], sa_m, d); sb_m = nxt_sec(pb_m[4], sb_m, d);
    end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_resume();
    @(negedge clk);
    resume_evt = 1'b1;
    pa_m[4] = 1'b0;   // clearing variant
    @(negedge clk);
    resume_evt = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    cfg_addr = a;
    #1;
    it.exp_a = (a == PA) ? pa_m : (a == SA) ? sa_m : 8'h00;
    it.exp_b = (a == PA) ? pb_m : (a == SA) ? sb_m : 8'h00;
    it.tag = tag;
    sb_q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic out_chk(input string tag);
    logic [11:0] act, exp;
    @(negedge clk);
    act = {wo_a, lk_a, ge_a, bs_a, he_a, ts_a, te_a, 2'b00};
    exp = {pa_m[6], pa_m[4], pa_m[3], pa_m[2:0], sa_m[7], sa_m[2:1], sa_m[0], 2'b00};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s outputs: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    rd_chk(PA, "R1 primary reset value");
    rd_chk(SA, "R1 secondary reset value");
    out_chk("R1 reset decode");

    rd_chk(8'h20, "R10 unmapped read");
    wr(8'h20, 8'hFF);
    rd_chk(PA, "R10 unmapped write primary");
    rd_chk(SA, "R10 unmapped write secondary");

    wr(PA, 8'h4A);
    rd_chk(PA, "R2 primary write 4A");
    out_chk("R9 decode primary");

    wr(PA, 8'h68);
    rd_chk(PA, "R7 open+close gives 28");

    wr(SA, 8'h87);
    rd_chk(SA, "R2 secondary write 87");
    out_chk("R9 decode secondary");

    wr(PA, 8'h5B);
    rd_chk(PA, "R4 R3 lock with open gives 1B");
    out_chk("R3 lock visible");

    wr(PA, 8'hE4);
    rd_chk(PA, "R5 locked primary gives BB");
    out_chk("R3 lock stays");

    wr(SA, 8'h78);
    rd_chk(SA, "R6 locked secondary gives FF");
    wr(SA, 8'h00);
    rd_chk(SA, "R6 locked secondary gives 87");

    pulse_resume();
    rd_chk(PA, "R8 resume policy");

    wr(PA, 8'h4B);
    rd_chk(PA, "R8 reopen after resume");
    out_chk("R8 window reopened");
    wr(PA, 8'h13);
    rd_chk(PA, "R8 relock");
    wr(PA, 8'h53);
    rd_chk(PA, "R4 relocked open stays 0");

    do_reset();
    rd_chk(PA, "R1 R3 full reset clears lock");
    rd_chk(SA, "R1 secondary after full reset");
    wr(PA, 8'h4A);
    rd_chk(PA, "R3 writable after full reset");
    out_chk("R9 decode after reset");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule